// File: doc/BRIEF.md
# Redundant core pair request front end for a shared cache

This block sits between a pair of redundant cores and a shared last-level cache. One core of the pair is the vocal core, the only one whose traffic reaches the coherent memory system. The other is the mute core, which runs the same program but whose results must never leave its private hierarchy. Vocal reads and write-backs go to the cache on the normal coherent path. Mute reads become phantom lookups that never touch coherence state. Mute write-backs and evictions are accepted and then discarded.

A phantom lookup has three search depths, picked by a strength input. The null depth answers at once with a fixed filler word. The shared depth looks up the shared cache and uses the filler only on a miss. The global depth also probes the vocal core's private caches and then reads memory. When the pair reaches a synchronizing access, the first request to arrive is parked in a single pending slot. The partner's request for the same block then starts one coherent write-permission transaction. Its data is returned to both cores in the same cycle.

The cache, the probe of the vocal private caches and memory are each modelled as a one-cycle request pulse followed by a response pulse after any latency. The block handles one transaction at a time.

Top module: `twin_llc_gate`

## Requirements
- R1: A vocal read (kind 0) issues one cache request with command 0 (coherent read). The vocal reply carries the cache response data, with its write-permission flag low.
- R2: A vocal write-back (kind 1) or eviction (kind 2) issues one cache request with command 2, carrying the vocal write data. No reply goes to either core.
- R3: A mute write-back (kind 1) or eviction (kind 2) is accepted and dropped. No cache, probe or memory request follows, and no reply is sent.
- R4: With strength 0 (null), a mute read is answered in the cycle after acceptance with data 0xDEADBEEF. No downstream request is made.
- R5: With strength 1 (shared), a mute read issues a cache request with command 1 (phantom lookup). A hit returns the cache data and a miss returns 0xDEADBEEF. The probe and memory ports are never used.
- R6: With strength 2 (global), a mute read first issues a phantom cache lookup. On a miss it probes the vocal private caches, and if that also misses it reads memory. The first data found is returned.
- R7: Every reply to the mute core has its write-permission flag high.
- R8: The first synchronizing request (kind 3) from either core is held in the pending slot. Until the partner's request arrives, no downstream request and no reply is produced.
- R9: A synchronizing request from the other core with the same block address starts exactly one cache request with command 3 (coherent write permission). Both cores then get a reply in the same cycle, with identical data and the write-permission flag high.
- R10: A second synchronizing request with a different address, or from the core that already holds the pending slot, pulses sync_err for one cycle. That request is dropped and the pending slot is kept.
- R11: When both cores present a request while the block is idle, the vocal request is accepted first.
- R12: After reset, no reply, no downstream request and no error is asserted, and the block is ready for vocal requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strength | input | 2 | Phantom depth: 0 null, 1 shared, 2 or 3 global |
| v_req_valid | input | 1 | Vocal request present |
| v_req_ready | output | 1 | Vocal request accepted this cycle when valid |
| v_req_kind | input | 2 | 0 read, 1 write-back, 2 eviction, 3 synchronizing |
| v_req_addr | input | AW | Vocal block address |
| v_req_wdata | input | DW | Vocal write-back data |
| v_rsp_valid | output | 1 | Vocal reply pulse |
| v_rsp_data | output | DW | Vocal reply data |
| v_rsp_wperm | output | 1 | Write permission granted with vocal reply |
| m_req_valid | input | 1 | Mute request present |
| m_req_ready | output | 1 | Mute request accepted this cycle when valid |
| m_req_kind | input | 2 | Same encoding as v_req_kind |
| m_req_addr | input | AW | Mute block address |
| m_rsp_valid | output | 1 | Mute reply pulse |
| m_rsp_data | output | DW | Mute reply data |
| m_rsp_wperm | output | 1 | Write permission inside the mute hierarchy |
| sync_err | output | 1 | Pulse on an unpaired synchronizing request |
| llc_req_valid | output | 1 | Cache request pulse |
| llc_req_cmd | output | 2 | 0 coherent read, 1 phantom lookup, 2 write-back, 3 write permission |
| llc_req_addr | output | AW | Cache request address |
| llc_req_wdata | output | DW | Cache write-back data |
| llc_rsp_valid | input | 1 | Cache response pulse |
| llc_rsp_hit | input | 1 | Phantom lookup hit |
| llc_rsp_data | input | DW | Cache response data |
| peer_req_valid | output | 1 | Vocal private cache probe pulse |
| peer_req_addr | output | AW | Probe address |
| peer_rsp_valid | input | 1 | Probe response pulse |
| peer_rsp_hit | input | 1 | Probe found the block |
| peer_rsp_data | input | DW | Probe data |
| mem_req_valid | output | 1 | Memory read pulse |
| mem_req_addr | output | AW | Memory read address |
| mem_rsp_valid | input | 1 | Memory response pulse |
| mem_rsp_data | input | DW | Memory data |

## Verification
If the sequencer reaches a wrong state, it shows up as a missing or extra request pulse on one of the three downstream ports. It also shows up as a reply that never comes or comes with the filler word, and these symptoms appear within a few cycles of the response that should have been routed. A corrupted pending slot shows either as a sync_err pulse on a correctly paired request, or as a cache request issued after only one synchronizing request. A reply that reaches only one core, or a pair of replies split across two cycles, also exposes it. Mute traffic that leaks is seen directly as an extra pulse on the cache port. Stimulus mixes random reads from both cores at all three strengths with directed pairing, mismatch and priority cases.

// File: rtl/twin_llc_gate.sv
module twin_llc_gate #(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter logic [DW-1:0] JUNK = 32'hDEADBEEF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    strength,
  input  logic          v_req_valid,
  output logic          v_req_ready,
  input  logic [1:0]    v_req_kind,
  input  logic [AW-1:0] v_req_addr,
  input  logic [DW-1:0] v_req_wdata,
  output logic          v_rsp_valid,
  output logic [DW-1:0] v_rsp_data,
  output logic          v_rsp_wperm,
  input  logic          m_req_valid,
  output logic          m_req_ready,
  input  logic [1:0]    m_req_kind,
  input  logic [AW-1:0] m_req_addr,
  output logic          m_rsp_valid,
  output logic [DW-1:0] m_rsp_data,
  output logic          m_rsp_wperm,
  output logic          sync_err,
  output logic          llc_req_valid,
  output logic [1:0]    llc_req_cmd,
  output logic [AW-1:0] llc_req_addr,
  output logic [DW-1:0] llc_req_wdata,
  input  logic          llc_rsp_valid,
  input  logic          llc_rsp_hit,
  input  logic [DW-1:0] llc_rsp_data,
  output logic          peer_req_valid,
  output logic [AW-1:0] peer_req_addr,
  input  logic          peer_rsp_valid,
  input  logic          peer_rsp_hit,
  input  logic [DW-1:0] peer_rsp_data,
  output logic          mem_req_valid,
  output logic [AW-1:0] mem_req_addr,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_data
);
  localparam logic [1:0] K_RD = 2'd0, K_SYNC = 2'd3;
  localparam logic [1:0] C_RD = 2'd0, C_PH = 2'd1, C_WB = 2'd2, C_SYNC = 2'd3;

  typedef enum logic [2:0] {S_IDLE, S_LREQ, S_LWAIT, S_PREQ, S_PWAIT, S_MREQ, S_MWAIT} st_t;
  st_t st;

  logic          cur_glob;
  logic [1:0]    cur_cmd;
  logic [AW-1:0] cur_addr;
  logic [DW-1:0] cur_wdata;
  logic          pend_v, pend_mute;
  logic [AW-1:0] pend_addr;

  wire           idle    = (st == S_IDLE);
  wire           take_v  = idle && v_req_valid;
  wire           take_m  = idle && !v_req_valid && m_req_valid;
  wire [1:0]     in_kind = v_req_valid ? v_req_kind : m_req_kind;
  wire [AW-1:0]  in_addr = v_req_valid ? v_req_addr : m_req_addr;
  wire           pair_ok = pend_v && (pend_mute == take_m) == 1'b0 && pend_addr == in_addr;

  assign v_req_ready    = idle;
  assign m_req_ready    = idle && !v_req_valid;
  assign llc_req_valid  = (st == S_LREQ);
  assign llc_req_cmd    = cur_cmd;
  assign llc_req_addr   = cur_addr;
  assign llc_req_wdata  = cur_wdata;
  assign peer_req_valid = (st == S_PREQ);
  assign peer_req_addr  = cur_addr;
  assign mem_req_valid  = (st == S_MREQ);
  assign mem_req_addr   = cur_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      cur_glob    <= 1'b0;
      cur_cmd     <= C_RD;
      cur_addr    <= '0;
      cur_wdata   <= '0;
      pend_v      <= 1'b0;
      pend_mute   <= 1'b0;
      pend_addr   <= '0;
      v_rsp_valid <= 1'b0;
      v_rsp_data  <= '0;
      v_rsp_wperm <= 1'b0;
      m_rsp_valid <= 1'b0;
      m_rsp_data  <= '0;
      m_rsp_wperm <= 1'b0;
      sync_err    <= 1'b0;
    end else begin
      v_rsp_valid <= 1'b0;
      m_rsp_valid <= 1'b0;
      sync_err    <= 1'b0;
      case (st)
        S_IDLE: if (take_v || take_m) begin
          cur_addr  <= in_addr;
          cur_wdata <= v_req_wdata;
          cur_glob  <= strength[1];
          if (in_kind == K_SYNC) begin
            if (!pend_v) begin
              pend_v    <= 1'b1;
              pend_mute <= take_m;
              pend_addr <= in_addr;
            end else if (pair_ok) begin
              pend_v  <= 1'b0;
              cur_cmd <= C_SYNC;
              st      <= S_LREQ;
            end else begin
              sync_err <= 1'b1;
            end
          end else if (take_v) begin
            cur_cmd <= (in_kind == K_RD) ? C_RD : C_WB;
            st      <= S_LREQ;
          end else if (in_kind == K_RD) begin
            if (strength == 2'd0) begin
              m_rsp_valid <= 1'b1;
              m_rsp_data  <= JUNK;
              m_rsp_wperm <= 1'b1;
            end else begin
              cur_cmd <= C_PH;
              st      <= S_LREQ;
            end
          end
        end
        S_LREQ: st <= S_LWAIT;
        S_LWAIT: if (llc_rsp_valid) begin
          st <= S_IDLE;
          case (cur_cmd)
            C_RD: begin
              v_rsp_valid <= 1'b1;
              v_rsp_data  <= llc_rsp_data;
              v_rsp_wperm <= 1'b0;
            end
            C_SYNC: begin
              v_rsp_valid <= 1'b1;
              v_rsp_data  <= llc_rsp_data;
              v_rsp_wperm <= 1'b1;
              m_rsp_valid <= 1'b1;
              m_rsp_data  <= llc_rsp_data;
              m_rsp_wperm <= 1'b1;
            end
            C_PH: begin
              if (llc_rsp_hit || !cur_glob) begin
                m_rsp_valid <= 1'b1;
                m_rsp_data  <= llc_rsp_hit ? llc_rsp_data : JUNK;
                m_rsp_wperm <= 1'b1;
              end else begin
                st <= S_PREQ;
              end
            end
            default: ;
          endcase
        end
        S_PREQ: st <= S_PWAIT;
        S_PWAIT: if (peer_rsp_valid) begin
          if (peer_rsp_hit) begin
            m_rsp_valid <= 1'b1;
            m_rsp_data  <= peer_rsp_data;
            m_rsp_wperm <= 1'b1;
            st          <= S_IDLE;
          end else begin
            st <= S_MREQ;
          end
        end
        S_MREQ: st <= S_MWAIT;
        S_MWAIT: if (mem_rsp_valid) begin
          m_rsp_valid <= 1'b1;
          m_rsp_data  <= mem_rsp_data;
          m_rsp_wperm <= 1'b1;
          st          <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/twin_llc_gate_chk.sv
module twin_llc_gate_chk #(
  parameter int DW = 32,
  parameter logic [DW-1:0] JUNK = 32'hDEADBEEF
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    strength,
  input logic          m_req_valid,
  input logic          m_req_ready,
  input logic [1:0]    m_req_kind,
  input logic          v_rsp_valid,
  input logic [DW-1:0] v_rsp_data,
  input logic          v_rsp_wperm,
  input logic          m_rsp_valid,
  input logic [DW-1:0] m_rsp_data,
  input logic          llc_req_valid,
  input logic          peer_req_valid,
  input logic          mem_req_valid
);
  p_mute_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (m_req_valid && m_req_ready && (m_req_kind == 2'd1 || m_req_kind == 2'd2))
    |=> (!llc_req_valid && !m_rsp_valid));

  p_null_junk_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (m_req_valid && m_req_ready && m_req_kind == 2'd0 && strength == 2'd0)
    |=> (m_rsp_valid && m_rsp_data == JUNK));

  p_one_port_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({llc_req_valid, peer_req_valid, mem_req_valid}));

  p_pair_same_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (v_rsp_valid && m_rsp_valid) |-> (v_rsp_data == m_rsp_data && v_rsp_wperm));

  p_llc_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    llc_req_valid |=> !llc_req_valid);
endmodule

bind twin_llc_gate twin_llc_gate_chk #(.DW(DW), .JUNK(JUNK)) u_chk (
  .clk(clk), .rst_n(rst_n), .strength(strength),
  .m_req_valid(m_req_valid), .m_req_ready(m_req_ready), .m_req_kind(m_req_kind),
  .v_rsp_valid(v_rsp_valid), .v_rsp_data(v_rsp_data), .v_rsp_wperm(v_rsp_wperm),
  .m_rsp_valid(m_rsp_valid), .m_rsp_data(m_rsp_data),
  .llc_req_valid(llc_req_valid), .peer_req_valid(peer_req_valid), .mem_req_valid(mem_req_valid)
);

// File: tb/tb_twin_llc_gate.sv
`timescale 1ns/1ps
module tb_twin_llc_gate;
  localparam logic [31:0] JUNK = 32'hDEADBEEF;
  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic [1:0] strength = 0;
  logic v_req_valid = 0, m_req_valid = 0;
  logic [1:0] v_req_kind = 0, m_req_kind = 0;
  logic [15:0] v_req_addr = 0, m_req_addr = 0;
  logic [31:0] v_req_wdata = 0;
  logic v_req_ready, m_req_ready, v_rsp_valid, v_rsp_wperm, m_rsp_valid, m_rsp_wperm, sync_err;
  logic [31:0] v_rsp_data, m_rsp_data;
  logic llc_req_valid, peer_req_valid, mem_req_valid;
  logic [1:0] llc_req_cmd;
  logic [15:0] llc_req_addr, peer_req_addr, mem_req_addr;
  logic [31:0] llc_req_wdata;
  logic llc_rsp_valid = 0, llc_rsp_hit = 0, peer_rsp_valid = 0, peer_rsp_hit = 0, mem_rsp_valid = 0;
  logic [31:0] llc_rsp_data = 0, peer_rsp_data = 0, mem_rsp_data = 0;

  twin_llc_gate dut (.*);

  int total = 0, bad = 0, cyc = 0;
  int n_llc = 0, n_peer = 0, n_mem = 0, v_cnt = 0, m_cnt = 0, err_cnt = 0, v_cyc = 0, m_cyc = 0;
  logic [1:0] last_cmd; logic [15:0] last_addr; logic [31:0] last_wd;
  logic [31:0] v_last, m_last; logic v_last_wp, m_last_wp;

  function automatic bit llc_hit(input logic [15:0] a); return (a % 3) != 0; endfunction
  function automatic logic [31:0] llc_data(input logic [15:0] a); return 32'hC000_0000 | 32'(a); endfunction
  function automatic bit peer_hit(input logic [15:0] a); return a[2]; endfunction
  function automatic logic [31:0] peer_data(input logic [15:0] a); return 32'hB000_0000 | 32'(a); endfunction
  function automatic logic [31:0] mem_data(input logic [15:0] a); return 32'hA000_0000 | 32'(a); endfunction
  function automatic logic [31:0] exp_ph(input logic [1:0] s, input logic [15:0] a);
    if (s == 0) return JUNK;
    if (llc_hit(a)) return llc_data(a);
    if (s == 1) return JUNK;
    if (peer_hit(a)) return peer_data(a);
    return mem_data(a);
  endfunction

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (v_rsp_valid) begin v_cnt++; v_last = v_rsp_data; v_last_wp = v_rsp_wperm; v_cyc = cyc; end
    if (m_rsp_valid) begin m_cnt++; m_last = m_rsp_data; m_last_wp = m_rsp_wperm; m_cyc = cyc; end
    if (sync_err) err_cnt++;
  end

  initial forever begin
    @(negedge clk);
    if (llc_req_valid) begin
      logic [1:0] c; logic [15:0] a;
      c = llc_req_cmd; a = llc_req_addr;
      n_llc++; last_cmd = c; last_addr = a; last_wd = llc_req_wdata;
      repeat ($urandom_range(1, 3)) @(negedge clk);
      llc_rsp_valid = 1; llc_rsp_hit = (c == 2'd1) ? llc_hit(a) : 1'b1; llc_rsp_data = llc_data(a);
      @(negedge clk); llc_rsp_valid = 0;
    end
  end
  initial forever begin
    @(negedge clk);
    if (peer_req_valid) begin
      logic [15:0] a;
      a = peer_req_addr; n_peer++;
      repeat ($urandom_range(1, 3)) @(negedge clk);
      peer_rsp_valid = 1; peer_rsp_hit = peer_hit(a); peer_rsp_data = peer_data(a);
      @(negedge clk); peer_rsp_valid = 0;
    end
  end
  initial forever begin
    @(negedge clk);
    if (mem_req_valid) begin
      logic [15:0] a;
      a = mem_req_addr; n_mem++;
      repeat ($urandom_range(1, 3)) @(negedge clk);
      mem_rsp_valid = 1; mem_rsp_data = mem_data(a);
      @(negedge clk); mem_rsp_valid = 0;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin bad++; $display("FAIL %s act=%h exp=%h", req, act, exp); end
  endtask

  task automatic send(input bit mute, input logic [1:0] kind, input logic [15:0] a, input logic [31:0] wd);
    @(negedge clk);
    if (mute) begin m_req_valid = 1; m_req_kind = kind; m_req_addr = a; end
    else begin v_req_valid = 1; v_req_kind = kind; v_req_addr = a; v_req_wdata = wd; end
    #1;
    while (!(mute ? m_req_ready : v_req_ready)) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    if (mute) m_req_valid = 0; else v_req_valid = 0;
  endtask

  task automatic settle(); repeat (24) @(negedge clk); endtask

  task automatic mute_read(input logic [1:0] s, input logic [15:0] a, input string req);
    int m0, p0, e0, l0;
    strength = s; m0 = m_cnt; p0 = n_peer; e0 = n_mem; l0 = n_llc;
    send(1, 2'd0, a, 0); settle();
    check(m_cnt == m0 + 1, req, m_cnt, m0 + 1);
    check(m_last == exp_ph(s, a), req, m_last, exp_ph(s, a));
    check(m_last_wp == 1'b1, "R7", m_last_wp, 1);
    if (s == 0) check(n_llc == l0, "R4 no downstream", n_llc, l0);
    if (s == 1) check(n_peer == p0 && n_mem == e0, "R5 no probe/mem", n_peer + n_mem, p0 + e0);
  endtask

  task automatic sync_pair(input bit first_mute, input logic [15:0] a);
    int l0, v0, m0;
    l0 = n_llc; v0 = v_cnt; m0 = m_cnt;
    send(first_mute, 2'd3, a, 0); settle();
    check(n_llc == l0 && v_cnt == v0 && m_cnt == m0, "R8 held", n_llc, l0);
    send(!first_mute, 2'd3, a, 0); settle();
    check(n_llc == l0 + 1 && last_cmd == 2'd3 && last_addr == a, "R9 one txn", n_llc, l0 + 1);
    check(v_cnt == v0 + 1 && m_cnt == m0 + 1 && v_cyc == m_cyc, "R9 same cycle", v_cyc, m_cyc);
    check(v_last == llc_data(a) && m_last == llc_data(a), "R9 data", m_last, llc_data(a));
    check(v_last_wp && m_last_wp, "R9 wperm", {v_last_wp, m_last_wp}, 2'b11);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=%0d exp=done", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    @(negedge clk); #1;
    // R12 reset state
    check(v_req_ready && !v_rsp_valid && !m_rsp_valid && !sync_err, "R12 outputs", {v_req_ready, v_rsp_valid, m_rsp_valid, sync_err}, 4'b1000);
    check(!llc_req_valid && !peer_req_valid && !mem_req_valid, "R12 req", {llc_req_valid, peer_req_valid, mem_req_valid}, 0);

    begin : r1_read
      int l0, v0;
      l0 = n_llc; v0 = v_cnt;
      send(0, 2'd0, 16'h0011, 0); settle();
      check(n_llc == l0 + 1 && last_cmd == 2'd0, "R1 cmd", last_cmd, 0);
      check(v_cnt == v0 + 1 && v_last == llc_data(16'h0011) && !v_last_wp, "R1 data", v_last, llc_data(16'h0011));
    end
    begin : r2_wb
      int l0, v0, m0;
      l0 = n_llc; v0 = v_cnt; m0 = m_cnt;
      send(0, 2'd1, 16'h0022, 32'h55AA_33CC); settle();
      check(n_llc == l0 + 1 && last_cmd == 2'd2 && last_wd == 32'h55AA_33CC, "R2 wb", last_wd, 32'h55AA_33CC);
      send(0, 2'd2, 16'h0023, 32'h1234_0000); settle();
      check(n_llc == l0 + 2 && last_cmd == 2'd2 && v_cnt == v0 && m_cnt == m0, "R2 evict", v_cnt, v0);
    end
    begin : r3_drop
      int l0, m0, v0;
      l0 = n_llc + n_peer + n_mem; m0 = m_cnt; v0 = v_cnt;
      send(1, 2'd1, 16'h0031, 0); settle();
      send(1, 2'd2, 16'h0032, 0); settle();
      check(n_llc + n_peer + n_mem == l0, "R3 no downstream", n_llc + n_peer + n_mem, l0);
      check(m_cnt == m0 && v_cnt == v0, "R3 no reply", m_cnt, m0);
    end

    mute_read(2'd0, 16'h0004, "R4");
    mute_read(2'd1, 16'h0004, "R5 hit");
    mute_read(2'd1, 16'h0006, "R5 miss");
    mute_read(2'd2, 16'h0005, "R6 llc hit");
    mute_read(2'd2, 16'h000C, "R6 peer hit");
    mute_read(2'd2, 16'h0009, "R6 mem");
    mute_read(2'd3, 16'h0003, "R6 mem s3");

    sync_pair(1, 16'h0005);
    sync_pair(0, 16'h0009);

    begin : r10_mismatch
      int e0, l0;
      e0 = err_cnt; l0 = n_llc;
      send(0, 2'd3, 16'h0007, 0); settle();
      send(1, 2'd3, 16'h0008, 0); settle();
      check(err_cnt == e0 + 1 && n_llc == l0, "R10 addr", err_cnt, e0 + 1);
      send(1, 2'd3, 16'h0007, 0); settle();
      check(n_llc == l0 + 1 && last_addr == 16'h0007 && v_cyc == m_cyc, "R10 kept", last_addr, 16'h0007);
      e0 = err_cnt; l0 = n_llc;
      send(0, 2'd3, 16'h0004, 0); settle();
      send(0, 2'd3, 16'h0004, 0); settle();
      check(err_cnt == e0 + 1 && n_llc == l0, "R10 same core", err_cnt, e0 + 1);
      send(1, 2'd3, 16'h0004, 0); settle();
      check(n_llc == l0 + 1 && m_last == llc_data(16'h0004), "R10 pair after", m_last, llc_data(16'h0004));
    end

    begin : r11_prio
      int v0, m0;
      v0 = v_cnt; m0 = m_cnt; strength = 0;
      @(negedge clk);
      v_req_valid = 1; v_req_kind = 0; v_req_addr = 16'h0002;
      m_req_valid = 1; m_req_kind = 0; m_req_addr = 16'h0006;
      #1;
      check(v_req_ready && !m_req_ready, "R11 ready", {v_req_ready, m_req_ready}, 2'b10);
      @(posedge clk); #1; v_req_valid = 0;
      @(negedge clk); #1;
      while (!m_req_ready) begin @(negedge clk); #1; end
      @(posedge clk); #1; m_req_valid = 0;
      settle();
      check(v_cnt == v0 + 1 && m_cnt == m0 + 1 && v_cyc < m_cyc, "R11 order", v_cyc, m_cyc);
    end

    for (int i = 0; i < 150; i++) begin
      logic [15:0] a; logic [1:0] s;
      a = 16'($urandom_range(0, 31)); s = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 1) == 0) begin
        int v0; v0 = v_cnt;
        send(0, 2'd0, a, 0); settle();
        check(v_cnt == v0 + 1 && v_last == llc_data(a), "R1 random", v_last, llc_data(a));
      end else begin
        mute_read(s, a, (s == 0) ? "R4 random" : (s == 1) ? "R5 random" : "R6 random");
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule